// File: doc/BRIEF.md
# Longest Run of Ones Finder by Erosion

This block takes a data word in parallel and reports how many bits its longest unbroken run of ones contains. It does not walk the word bit by bit. It repeatedly erodes the whole word at once. In each step, every bit keeps its value only if the bit just below it is also set. The bit below the least significant position is treated as a constant zero. Each run of ones therefore loses one bit per step. The number of steps taken before the word becomes all zero is the length of the longest run.

A client pulses the start input with a word while the block is idle. The block then raises its busy flag and erodes the word once per clock. When it sees the word is all zero, it drops busy, raises a one-cycle done pulse and presents the step count on the length output. The length output holds that value until the next job finishes. Latency depends on the data: a word whose longest run is L finishes L+1 cycles after it is loaded.

Top module: `run_length_eroder`

## Requirements
- R1: After a synchronous reset, busy_o, done_o and length_o are all 0.
- R2: A start_i sampled high while busy_o is low loads word_i, and busy_o is high in the following cycle.
- R3: Each step replaces the word w with w AND (w shifted left by one, with a 0 entering at bit 0). The reported length therefore equals the longest run of consecutive 1 bits in word_i. For example, 16'b0111101001110011 reports 4.
- R4: For a word whose longest run is L, busy_o stays high for exactly L+1 cycles after the load edge. done_o is high in the cycle right after the last busy cycle.
- R5: done_o is a single-cycle pulse, and busy_o is low whenever done_o is high.
- R6: An all-zero word reports length 0 after a single busy cycle.
- R7: An all-ones word of N bits reports N (16 for the default), which needs the full ceil(log2(N+1))-bit result width.
- R8: A start_i sampled while busy_o is high is ignored. The job in flight finishes with its own result and timing.
- R9: length_o changes only in the cycle when done_o is high, and holds that value until the next done. A start_i given in the done cycle is accepted at once.
- R10: length_o never exceeds N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load strobe, sampled while idle |
| word_i | input | N | Word to measure |
| busy_o | output | 1 | Erosion job in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| length_o | output | ceil(log2(N+1)) | Length of the longest run of ones in the last finished word |

## Verification
The done pulse of one job and the acceptance of the next start can happen in the same cycle. This is because busy is already low when done is high. The bench holds start_i high through the done cycle and changes the word at that point. It then judges against a behavioural model, compared on every clock, that the new word is loaded at the next edge. It also checks that length_o keeps the previous result until the new job's done pulse. A start given mid-job is checked separately to confirm it changes neither the result nor the timing.

// File: rtl/rle_pkg.sv
package rle_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ERODE = 1'b1
    } rle_phase_e;

    function automatic int rle_count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rle_erode_stage.sv
module rle_erode_stage #(
    parameter int W = 16
) (
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] bits_o
);
    // Each surviving bit needs its lower neighbour set; below bit 0 sits a 0.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_floor
            assign bits_o[i] = 1'b0;
        end else begin : g_upper
            assign bits_o[i] = bits_i[i] & bits_i[i-1];
        end
    end
endmodule

// File: rtl/rle_zero_detect.sv
module rle_zero_detect #(
    parameter int W = 16,
    parameter int G = 4
) (
    input  logic [W-1:0] vec_i,
    output logic         zero_o
);
    localparam int NCH = (W + G - 1) / G;
    localparam int PW  = NCH * G;

    logic [PW-1:0]  padded;
    logic [NCH-1:0] part_any;

    always_comb begin
        padded         = '0;
        padded[W-1:0]  = vec_i;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        assign part_any[c] = |padded[c*G +: G];
    end

    assign zero_o = ~|part_any;
endmodule

// File: rtl/run_length_eroder.sv
module run_length_eroder
    import rle_pkg::*;
#(
    parameter int N = 16,
    localparam int CW = rle_count_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [N-1:0]  word_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [CW-1:0] length_o
);
    typedef struct packed {
        rle_phase_e    phase;
        logic          done;
        logic [N-1:0]  bits;
        logic [CW-1:0] steps;
        logic [CW-1:0] result;
    } core_t;

    core_t        st_q, st_d;
    logic [N-1:0] eroded;
    logic         bits_zero;

    rle_erode_stage #(.W(N)) u_erode (
        .bits_i (st_q.bits),
        .bits_o (eroded)
    );

    rle_zero_detect #(.W(N), .G(4)) u_zero (
        .vec_i  (st_q.bits),
        .zero_o (bits_zero)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_ERODE;
                    st_d.bits  = word_i;
                    st_d.steps = '0;
                end
            end
            PH_ERODE: begin
                // Zero check happens before a step, so steps equals erosions applied.
                if (bits_zero) begin
                    st_d.phase  = PH_IDLE;
                    st_d.done   = 1'b1;
                    st_d.result = st_q.steps;
                end else begin
                    st_d.bits  = eroded;
                    st_d.steps = st_q.steps + CW'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.phase == PH_ERODE);
    assign done_o   = st_q.done;
    assign length_o = st_q.result;
endmodule

// File: rtl/rle_checker.sv
module rle_checker #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [N-1:0]  word_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [CW-1:0] length_o
);
    logic unused_word;
    assign unused_word = ^word_i;

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_idle_at_done_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(busy_o));

    p_busy_until_done_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (busy_o || done_o));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(length_o) |-> done_o);

    p_bound_r10: assert property (@(posedge clk) disable iff (rst)
        int'(length_o) <= N);
endmodule

bind run_length_eroder rle_checker #(.N(N)) u_chk (.*);

// File: tb/run_length_eroder_tb.sv
module run_length_eroder_tb;
    localparam int N  = 16;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [N-1:0]  word_i = '0;
    logic          busy_o, done_o;
    logic [CW-1:0] length_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    run_length_eroder #(.N(N)) u_dut (.*);

    always #5 clk = ~clk;

    // Behavioural reference: longest run by a plain scan.
    function automatic int longest_run(input logic [N-1:0] w);
        int best = 0;
        int cur  = 0;
        for (int i = 0; i < N; i++) begin
            if (w[i]) begin
                cur++;
                if (cur > best) best = cur;
            end else begin
                cur = 0;
            end
        end
        return best;
    endfunction

    logic m_busy = 1'b0, m_done = 1'b0;
    int   m_len = 0, m_rem = 0, m_pend = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_len <= 0; m_rem <= 0; m_pend <= 0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy <= 1'b1;
                    m_rem  <= longest_run(word_i);
                    m_pend <= longest_run(word_i);
                end
            end else if (m_rem == 0) begin
                m_busy <= 1'b0;
                m_done <= 1'b1;
                m_len  <= m_pend;
            end else begin
                m_rem <= m_rem - 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, int'(busy_o), int'(m_busy), "busy_o");
            check(cur_req, int'(done_o), int'(m_done), "done_o");
            check(cur_req, int'(length_o), m_len, "length_o");
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles == 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic pulse_start(input logic [N-1:0] w);
        @(negedge clk);
        start_i = 1'b1;
        word_i  = w;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    task automatic run_word(input string req, input logic [N-1:0] w);
        int busy_cycles = 0;
        cur_req = req;
        pulse_start(w);
        while (busy_o) begin
            busy_cycles++;
            @(negedge clk);
        end
        check(req, int'(done_o), 1, "done after busy");
        check(req, int'(length_o), longest_run(w), "result");
        check("R4", busy_cycles, longest_run(w) + 1, "busy length");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", int'(busy_o), 0, "reset busy");
        check("R1", int'(done_o), 0, "reset done");
        check("R1", int'(length_o), 0, "reset length");
        rst = 1'b0;
        @(negedge clk);

        // R2 and R3: worked example, longest run 4
        cur_req = "R2";
        pulse_start(16'b0111101001110011);
        check("R2", int'(busy_o), 1, "busy after load");
        cur_req = "R3";
        wait_done();
        check("R3", int'(length_o), 4, "example result");
        @(negedge clk);

        run_word("R6", 16'h0000);
        run_word("R7", 16'hFFFF);
        run_word("R3", 16'h8000);
        run_word("R3", 16'hAAAA);
        run_word("R3", 16'h7FFE);
        run_word("R3", 16'h8001);
        run_word("R3", 16'hFF00);
        run_word("R3", 16'h00FF);
        run_word("R10", 16'hFFFF);

        // R8: a start mid-job is ignored
        cur_req = "R8";
        pulse_start(16'h0F0F);
        start_i = 1'b1;
        word_i  = 16'hFFFF;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check("R8", int'(length_o), 4, "mid-job start ignored");
        @(negedge clk);
        check("R8", int'(busy_o), 0, "no extra job");

        // R9: start held through the done cycle, new word loaded at once
        cur_req = "R9";
        @(negedge clk);
        start_i = 1'b1;
        word_i  = 16'h03F0;
        @(negedge clk);
        while (!done_o) @(negedge clk);
        word_i = 16'h0007;
        @(negedge clk);
        start_i = 1'b0;
        check("R9", int'(busy_o), 1, "load in done cycle");
        check("R9", int'(length_o), 6, "previous result held");
        wait_done();
        check("R9", int'(length_o), 3, "second result");
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule